// File: doc/BRIEF.md
# I2C Interrupt Request Flag Collector

This block holds the one sticky interrupt-request flag of an I2C controller. The bus engine sends it single-cycle event pulses: start seen, transmit buffer loaded into the shift register, shift register moved into the receive buffer, acknowledge sampled, wait inserted, arbitration lost, own-address hit, general call hit and stop seen. The block also reads the current operating mode and a few enable, mask and buffer-status bits. It checks each event against the mode and the bit that gates it. Any event that passes sets the flag.

Software clears the flag by writing 0 to it. The interrupt line to the CPU is the flag ANDed with a global enable, taken from a register. A small tracker marks the first frame after a start. Address and general-call hits count only inside that frame, and each accepted hit also sets its own seen bit. The next start clears those seen bits.

Top module: `i2c_irq_merge`

## Requirements
- R1: When `mode_tx`=1 and `tx_empty`=1, an `ev_start` pulse sets `irq_flag` at the next clock edge. When either bit is 0, the pulse does not set the flag.
- R2: When `mode_tx`=1 and `tx_empty`=1, an `ev_tx_load` pulse sets `irq_flag`. When either bit is 0, the pulse does not set the flag.
- R3: When `mode_tx`=0 and `rx_full`=1, an `ev_rx_load` pulse sets `irq_flag`. When `mode_tx` is 1 or `rx_full` is 0, the pulse does not set the flag.
- R4: An `ev_ack_done` pulse with `ack_val`=1 sets `irq_flag` only when `mode_tx`=1 and `ack_chk_en`=1. An acknowledge value of 0 never sets the flag.
- R5: An `ev_wait` pulse sets `irq_flag` only when `i2c_fmt`=1, `mode_master`=1 and `wait_en`=1.
- R6: An `ev_arb_lost` pulse sets `irq_flag` only when `i2c_fmt`=1, `mode_master`=1 and `arb_ie`=1.
- R7: Slave mode means `i2c_fmt`=1 and `mode_master`=0. In slave mode, bit i of `ev_addr_hit` sets `irq_flag` and `addr_seen[i]` when it arrives inside the first frame after a start. The first frame begins after `ev_start` and ends after the first `ev_tx_load` or `ev_rx_load`. Outside the first frame, or outside slave mode, the hit does nothing. An `ev_start` clears `addr_seen`.
- R8: In slave mode and inside the first frame, `ev_gcall` sets `irq_flag` and `gcall_seen` only when `gcall_fs`=0. An `ev_start` clears `gcall_seen`.
- R9: In slave mode, `ev_stop` sets `irq_flag` only when `stop_mask`=0. In master mode a stop does not set the flag.
- R10: `irq_flag` is sticky. It stays at 1 until a cycle with `sw_wr`=1 and `sw_wdata`=0. A write of 1 leaves the flag unchanged. When a qualified set event and a clearing write fall in the same cycle, the flag stays at 1.
- R11: `irq_out` is registered. In each cycle it equals the previous cycle's `irq_flag` AND `irq_en`.
- R12: While `rst_n`=0, and after it, `irq_flag`, `irq_out`, `addr_seen` and `gcall_seen` are all 0. The first-frame marker is also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_master | input | 1 | 1 = master, 0 = slave |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| i2c_fmt | input | 1 | 1 = I2C bus format selected |
| tx_empty | input | 1 | Transmit-data-empty status |
| rx_full | input | 1 | Receive-data-full status |
| ack_chk_en | input | 1 | Enable checking of the received acknowledge bit |
| wait_en | input | 1 | Enable the interrupt on wait insertion |
| arb_ie | input | 1 | Arbitration-lost interrupt enable |
| gcall_fs | input | 1 | Format-select bit of the first address register; 1 blocks general call |
| stop_mask | input | 1 | 1 masks the stop interrupt |
| irq_en | input | 1 | Global interrupt enable |
| ev_start | input | 1 | Start condition detected (pulse) |
| ev_tx_load | input | 1 | Transmit buffer moved into shift register (pulse) |
| ev_rx_load | input | 1 | Shift register moved into receive buffer (pulse) |
| ev_ack_done | input | 1 | Acknowledge bit sampled (pulse) |
| ack_val | input | 1 | Sampled acknowledge value, valid with ev_ack_done |
| ev_wait | input | 1 | Wait inserted between data and acknowledge (pulse) |
| ev_arb_lost | input | 1 | Bus arbitration lost (pulse) |
| ev_addr_hit | input | N_ADDR | Own-address match, one bit per address (pulse) |
| ev_gcall | input | 1 | General call address detected (pulse) |
| ev_stop | input | 1 | Stop condition detected (pulse) |
| sw_wr | input | 1 | Software write strobe to the flag |
| sw_wdata | input | 1 | Value written with sw_wr |
| irq_flag | output | 1 | Sticky interrupt-request flag |
| irq_out | output | 1 | Registered interrupt line to the CPU |
| addr_seen | output | N_ADDR | Latched address-seen bits |
| gcall_seen | output | 1 | Latched general-call-seen bit |

## Verification
The assertions check some rules on every cycle. A set flag holds until a clearing write. A clear with no events present takes effect. `irq_out` follows the previous cycle's flag and enable. The flag never rises unless some event arrived in the previous cycle. An enabled arbitration loss always sets the flag. A start always clears the seen bits. A masked stop or a blocked general call leaves its state untouched. Other rules can only be shown by the bench's scenarios. These are each mode and gating combination in the table, the first-frame window closing after a buffer transfer, a set and a clear in the same cycle, and a reset applied in the middle of a run.

// File: rtl/i2c_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the interrupt flag collector.
// Assumes: the set of fixed (non-address) sources is fixed by function.
package i2c_irq_pkg;

    // Index of each fixed qualified source in the qualified vector.
    typedef enum int unsigned {
        SRC_START = 0,
        SRC_TXLD  = 1,
        SRC_RXLD  = 2,
        SRC_NACK  = 3,
        SRC_WAIT  = 4,
        SRC_ARB   = 5,
        SRC_GCALL = 6,
        SRC_STOP  = 7
    } src_e;

    localparam int NUM_FIXED = 8;

    // Operating mode as seen by the qualifier.
    typedef struct packed {
        logic master;
        logic tx;
        logic i2c_fmt;
    } mode_t;

    // Enable, mask and status bits that gate the sources.
    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic ack_chk_en;
        logic wait_en;
        logic arb_ie;
        logic gcall_fs;
        logic stop_mask;
    } gate_t;

endpackage

// File: rtl/i2c_irq_frame.sv
`timescale 1ns/1ps
// Module: first-frame tracker.
// Marks the window from a start condition up to and including the first
// buffer transfer. Assumes event inputs are single-cycle pulses.
module i2c_irq_frame (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_start,
    input  logic ev_tx_load,
    input  logic ev_rx_load,
    output logic first_frame
);

    // Open the window on start, close it after the first byte transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_frame <= 1'b0;
        end else if (ev_start) begin
            first_frame <= 1'b1;
        end else if (ev_tx_load || ev_rx_load) begin
            first_frame <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_irq_qualify.sv
`timescale 1ns/1ps
// Module: source qualifier.
// Gates each raw event with the mode and the status, enable or mask bit
// that applies to it. Purely combinational; assumes pulses last one cycle.
module i2c_irq_qualify
    import i2c_irq_pkg::*;
#(
    parameter int N_ADDR = 2
) (
    input  mode_t                mode,
    input  gate_t                gate,
    input  logic                 first_frame,
    input  logic                 ev_start,
    input  logic                 ev_tx_load,
    input  logic                 ev_rx_load,
    input  logic                 ev_ack_done,
    input  logic                 ack_val,
    input  logic                 ev_wait,
    input  logic                 ev_arb_lost,
    input  logic [N_ADDR-1:0]    ev_addr_hit,
    input  logic                 ev_gcall,
    input  logic                 ev_stop,
    output logic [NUM_FIXED-1:0] q_fixed,
    output logic [N_ADDR-1:0]    q_addr
);

    logic master_i2c;
    logic slave_i2c;

    // Derive the bus-format mode qualifiers.
    always_comb begin
        master_i2c = mode.i2c_fmt && mode.master;
        slave_i2c  = mode.i2c_fmt && !mode.master;
    end

    // Qualify each fixed source with its own gate.
    always_comb begin
        q_fixed            = '0;
        q_fixed[SRC_START] = ev_start    && mode.tx && gate.tx_empty;
        q_fixed[SRC_TXLD]  = ev_tx_load  && mode.tx && gate.tx_empty;
        q_fixed[SRC_RXLD]  = ev_rx_load  && !mode.tx && gate.rx_full;
        q_fixed[SRC_NACK]  = ev_ack_done && ack_val && mode.tx && gate.ack_chk_en;
        q_fixed[SRC_WAIT]  = ev_wait     && master_i2c && gate.wait_en;
        q_fixed[SRC_ARB]   = ev_arb_lost && master_i2c && gate.arb_ie;
        q_fixed[SRC_GCALL] = ev_gcall    && slave_i2c && first_frame && !gate.gcall_fs;
        q_fixed[SRC_STOP]  = ev_stop     && slave_i2c && !gate.stop_mask;
    end

    // One qualifier per programmable own address.
    for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
        assign q_addr[i] = ev_addr_hit[i] && slave_i2c && first_frame;
    end

endmodule

// File: rtl/i2c_irq_seen.sv
`timescale 1ns/1ps
// Module: latched match status.
// Holds one seen bit per own address and one for general call. A bit is
// set by its qualified hit and cleared by the next start; set wins.
module i2c_irq_seen #(
    parameter int N_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic [N_ADDR-1:0] q_addr,
    input  logic              q_gcall,
    output logic [N_ADDR-1:0] addr_seen,
    output logic              gcall_seen
);

    // One address-seen register per own address.
    for (genvar i = 0; i < N_ADDR; i++) begin : g_seen
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_seen[i] <= 1'b0;
            end else if (q_addr[i]) begin
                addr_seen[i] <= 1'b1;
            end else if (ev_start) begin
                addr_seen[i] <= 1'b0;
            end
        end
    end

    // General-call-seen register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcall_seen <= 1'b0;
        end else if (q_gcall) begin
            gcall_seen <= 1'b1;
        end else if (ev_start) begin
            gcall_seen <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_irq_flag.sv
`timescale 1ns/1ps
// Module: sticky request flag and registered interrupt line.
// Software clears the flag by writing 0; a write of 1 is ignored and a
// set request in the same cycle as a clear wins.
module i2c_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic sw_wr,
    input  logic sw_wdata,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic clr_req;

    // Decode the software clear.
    always_comb begin
        clr_req = sw_wr && !sw_wdata;
    end

    // Hold the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Register the gated line so it cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= flag && irq_en;
        end
    end

endmodule

// File: rtl/i2c_irq_merge.sv
`timescale 1ns/1ps
// Module: interrupt flag collector top.
// Qualifies bus-engine event pulses by mode and gate bits, keeps one
// sticky request flag, the match seen bits and the interrupt line.
// Assumes all event inputs are synchronous single-cycle pulses.
module i2c_irq_merge
    import i2c_irq_pkg::*;
#(
    parameter int N_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              mode_tx,
    input  logic              i2c_fmt,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              ack_chk_en,
    input  logic              wait_en,
    input  logic              arb_ie,
    input  logic              gcall_fs,
    input  logic              stop_mask,
    input  logic              irq_en,
    input  logic              ev_start,
    input  logic              ev_tx_load,
    input  logic              ev_rx_load,
    input  logic              ev_ack_done,
    input  logic              ack_val,
    input  logic              ev_wait,
    input  logic              ev_arb_lost,
    input  logic [N_ADDR-1:0] ev_addr_hit,
    input  logic              ev_gcall,
    input  logic              ev_stop,
    input  logic              sw_wr,
    input  logic              sw_wdata,
    output logic              irq_flag,
    output logic              irq_out,
    output logic [N_ADDR-1:0] addr_seen,
    output logic              gcall_seen
);

    mode_t                mode;
    gate_t                gate;
    logic                 first_frame;
    logic [NUM_FIXED-1:0] q_fixed;
    logic [N_ADDR-1:0]    q_addr;
    logic                 set_req;

    // Pack the plain ports into the internal structures.
    always_comb begin
        mode.master     = mode_master;
        mode.tx         = mode_tx;
        mode.i2c_fmt    = i2c_fmt;
        gate.tx_empty   = tx_empty;
        gate.rx_full    = rx_full;
        gate.ack_chk_en = ack_chk_en;
        gate.wait_en    = wait_en;
        gate.arb_ie     = arb_ie;
        gate.gcall_fs   = gcall_fs;
        gate.stop_mask  = stop_mask;
    end

    i2c_irq_frame frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_start    (ev_start),
        .ev_tx_load  (ev_tx_load),
        .ev_rx_load  (ev_rx_load),
        .first_frame (first_frame)
    );

    i2c_irq_qualify #(.N_ADDR(N_ADDR)) qual_i (
        .mode        (mode),
        .gate        (gate),
        .first_frame (first_frame),
        .ev_start    (ev_start),
        .ev_tx_load  (ev_tx_load),
        .ev_rx_load  (ev_rx_load),
        .ev_ack_done (ev_ack_done),
        .ack_val     (ack_val),
        .ev_wait     (ev_wait),
        .ev_arb_lost (ev_arb_lost),
        .ev_addr_hit (ev_addr_hit),
        .ev_gcall    (ev_gcall),
        .ev_stop     (ev_stop),
        .q_fixed     (q_fixed),
        .q_addr      (q_addr)
    );

    // Merge all qualified sources into one set request.
    always_comb begin
        set_req = (|q_fixed) || (|q_addr);
    end

    i2c_irq_seen #(.N_ADDR(N_ADDR)) seen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_start   (ev_start),
        .q_addr     (q_addr),
        .q_gcall    (q_fixed[SRC_GCALL]),
        .addr_seen  (addr_seen),
        .gcall_seen (gcall_seen)
    );

    i2c_irq_flag flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .irq_en   (irq_en),
        .flag     (irq_flag),
        .irq      (irq_out)
    );

endmodule

// File: rtl/i2c_irq_merge_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the interrupt flag collector, bound to the top.
// Observes ports only; assumes synchronous active-low reset.
module i2c_irq_merge_chk #(
    parameter int N_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_master,
    input logic              i2c_fmt,
    input logic              arb_ie,
    input logic              gcall_fs,
    input logic              stop_mask,
    input logic              irq_en,
    input logic              ev_start,
    input logic              ev_tx_load,
    input logic              ev_rx_load,
    input logic              ev_ack_done,
    input logic              ev_wait,
    input logic              ev_arb_lost,
    input logic [N_ADDR-1:0] ev_addr_hit,
    input logic              ev_gcall,
    input logic              ev_stop,
    input logic              sw_wr,
    input logic              sw_wdata,
    input logic              irq_flag,
    input logic              irq_out,
    input logic [N_ADDR-1:0] addr_seen,
    input logic              gcall_seen
);

    logic any_ev;
    logic other_ev;

    // Summarise event activity for the properties.
    always_comb begin
        other_ev = ev_start || ev_tx_load || ev_rx_load || ev_ack_done ||
                   ev_wait || ev_arb_lost || (|ev_addr_hit) || ev_gcall;
        any_ev   = other_ev || ev_stop;
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(sw_wr && !sw_wdata)) |=> irq_flag);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && sw_wr && !sw_wdata && !any_ev) |=> !irq_flag);

    assert_irq_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(irq_flag && irq_en)));

    assert_rise_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(any_ev));

    assert_arb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_arb_lost && i2c_fmt && mode_master && arb_ie) |=> irq_flag);

    assert_stop_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && stop_mask && !other_ev && !irq_flag) |=> !irq_flag);

    assert_seen_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !(|ev_addr_hit)) |=> (addr_seen == '0));

    assert_gcall_fs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_gcall && gcall_fs && !gcall_seen && !ev_start) |=> !gcall_seen);

endmodule

bind i2c_irq_merge i2c_irq_merge_chk #(.N_ADDR(N_ADDR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .i2c_fmt     (i2c_fmt),
    .arb_ie      (arb_ie),
    .gcall_fs    (gcall_fs),
    .stop_mask   (stop_mask),
    .irq_en      (irq_en),
    .ev_start    (ev_start),
    .ev_tx_load  (ev_tx_load),
    .ev_rx_load  (ev_rx_load),
    .ev_ack_done (ev_ack_done),
    .ev_wait     (ev_wait),
    .ev_arb_lost (ev_arb_lost),
    .ev_addr_hit (ev_addr_hit),
    .ev_gcall    (ev_gcall),
    .ev_stop     (ev_stop),
    .sw_wr       (sw_wr),
    .sw_wdata    (sw_wdata),
    .irq_flag    (irq_flag),
    .irq_out     (irq_out),
    .addr_seen   (addr_seen),
    .gcall_seen  (gcall_seen)
);

// File: tb/i2c_irq_merge_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_merge_tb_top;

    localparam int N_ADDR = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic mode_master, mode_tx, i2c_fmt, tx_empty, rx_full;
    logic ack_chk_en, wait_en, arb_ie, gcall_fs, stop_mask, irq_en;
    logic ev_start, ev_tx_load, ev_rx_load, ev_ack_done, ack_val;
    logic ev_wait, ev_arb_lost, ev_gcall, ev_stop;
    logic [N_ADDR-1:0] ev_addr_hit;
    logic sw_wr, sw_wdata;
    logic irq_flag, irq_out, gcall_seen;
    logic [N_ADDR-1:0] addr_seen;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    i2c_irq_merge #(.N_ADDR(N_ADDR)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .mode_tx(mode_tx),
        .i2c_fmt(i2c_fmt), .tx_empty(tx_empty), .rx_full(rx_full),
        .ack_chk_en(ack_chk_en), .wait_en(wait_en), .arb_ie(arb_ie),
        .gcall_fs(gcall_fs), .stop_mask(stop_mask), .irq_en(irq_en),
        .ev_start(ev_start), .ev_tx_load(ev_tx_load), .ev_rx_load(ev_rx_load),
        .ev_ack_done(ev_ack_done), .ack_val(ack_val), .ev_wait(ev_wait),
        .ev_arb_lost(ev_arb_lost), .ev_addr_hit(ev_addr_hit), .ev_gcall(ev_gcall),
        .ev_stop(ev_stop), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .irq_flag(irq_flag), .irq_out(irq_out), .addr_seen(addr_seen),
        .gcall_seen(gcall_seen)
    );

    // Event masks (10 bits) and gate/mode masks (11 bits) for the table.
    localparam logic [9:0] E_START = 10'd1,   E_TXLD = 10'd2,  E_RXLD = 10'd4;
    localparam logic [9:0] E_ACK   = 10'd8,   E_WAIT = 10'd16, E_ARB  = 10'd32;
    localparam logic [9:0] E_A0    = 10'd64,  E_A1   = 10'd128;
    localparam logic [9:0] E_GC    = 10'd256, E_STOP = 10'd512;
    localparam logic [10:0] C_NONE = 11'h000;
    localparam logic [10:0] C_ACKV = 11'h400, C_MST  = 11'h200, C_TX    = 11'h100;
    localparam logic [10:0] C_FMT  = 11'h080, C_TXE  = 11'h040, C_RXF   = 11'h020;
    localparam logic [10:0] C_ACKC = 11'h010, C_WAITE = 11'h008, C_ARBIE = 11'h004;
    localparam logic [10:0] C_GCFS = 11'h002, C_STOPM = 11'h001;

    localparam int NVEC = 23;
    // {requirement number, events, gates, expected flag}
    localparam logic [25:0] TBL [NVEC] = '{
        {4'd1,  E_START, C_TX | C_TXE, 1'b1},                 // R1
        {4'd1,  E_START, C_TX, 1'b0},                         // R1
        {4'd1,  E_START, C_TXE, 1'b0},                        // R1
        {4'd2,  E_TXLD,  C_TX | C_TXE, 1'b1},                 // R2
        {4'd2,  E_TXLD,  C_TX, 1'b0},                         // R2
        {4'd3,  E_RXLD,  C_RXF, 1'b1},                        // R3
        {4'd3,  E_RXLD,  C_TX | C_RXF, 1'b0},                 // R3
        {4'd4,  E_ACK,   C_ACKV | C_TX | C_ACKC, 1'b1},       // R4
        {4'd4,  E_ACK,   C_ACKV | C_TX, 1'b0},                // R4
        {4'd4,  E_ACK,   C_TX | C_ACKC, 1'b0},                // R4
        {4'd5,  E_WAIT,  C_MST | C_FMT | C_WAITE, 1'b1},      // R5
        {4'd5,  E_WAIT,  C_MST | C_FMT, 1'b0},                // R5
        {4'd5,  E_WAIT,  C_MST | C_WAITE, 1'b0},              // R5
        {4'd6,  E_ARB,   C_MST | C_FMT | C_ARBIE, 1'b1},      // R6
        {4'd6,  E_ARB,   C_FMT | C_ARBIE, 1'b0},              // R6
        {4'd7,  E_A0,    C_FMT, 1'b1},                        // R7
        {4'd7,  E_A1,    C_FMT, 1'b1},                        // R7
        {4'd7,  E_A0,    C_MST | C_FMT, 1'b0},                // R7
        {4'd8,  E_GC,    C_FMT, 1'b1},                        // R8
        {4'd8,  E_GC,    C_FMT | C_GCFS, 1'b0},               // R8
        {4'd9,  E_STOP,  C_FMT, 1'b1},                        // R9
        {4'd9,  E_STOP,  C_FMT | C_STOPM, 1'b0},              // R9
        {4'd9,  E_STOP,  C_MST | C_FMT, 1'b0}                 // R9
    };

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [9:0] ev, input logic [10:0] c);
        ev_start    = ev[0];
        ev_tx_load  = ev[1];
        ev_rx_load  = ev[2];
        ev_ack_done = ev[3];
        ev_wait     = ev[4];
        ev_arb_lost = ev[5];
        ev_addr_hit = ev[7:6];
        ev_gcall    = ev[8];
        ev_stop     = ev[9];
        ack_val     = c[10];
        mode_master = c[9];
        mode_tx     = c[8];
        i2c_fmt     = c[7];
        tx_empty    = c[6];
        rx_full     = c[5];
        ack_chk_en  = c[4];
        wait_en     = c[3];
        arb_ie      = c[2];
        gcall_fs    = c[1];
        stop_mask   = c[0];
    endtask

    task automatic step(input logic [9:0] ev, input logic [10:0] c);
        @(negedge clk);
        drive(ev, c);
        sw_wr = 1'b0;
        sw_wdata = 1'b0;
    endtask

    task automatic sw_write(input logic v);
        @(negedge clk);
        drive(10'd0, C_NONE);
        sw_wr = 1'b1;
        sw_wdata = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        irq_en = 1'b1;
        sw_wr = 1'b0;
        sw_wdata = 1'b0;
        drive(10'd0, C_NONE);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "flag in reset", irq_flag, 1'b0);
        chk("R12", "irq in reset", irq_out, 1'b0);
        chk("R12", "addr_seen in reset", |addr_seen, 1'b0);
        chk("R12", "gcall_seen in reset", gcall_seen, 1'b0);
        rst_n = 1'b1;

        // Table: prelude start (unqualified), vector, check flag, check irq, clear.
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            tag = $sformatf("R%0d", TBL[k][25:22]);
            step(E_START, C_NONE);
            step(TBL[k][21:12], TBL[k][11:1]);
            step(10'd0, C_NONE);
            chk(tag, $sformatf("vector %0d flag", k), irq_flag, TBL[k][0]);
            sw_write(1'b0);
            chk("R11", $sformatf("vector %0d irq", k), irq_out, TBL[k][0]);
            step(10'd0, C_NONE);
            chk("R10", $sformatf("vector %0d cleared", k), irq_flag, 1'b0);
        end

        // R7: seen bits follow the matching address and clear on start.
        step(E_START, C_NONE);
        step(E_A0, C_FMT);
        step(10'd0, C_NONE);
        chk("R7", "addr_seen[0] set", addr_seen[0], 1'b1);
        chk("R7", "addr_seen[1] untouched", addr_seen[1], 1'b0);
        chk("R7", "flag by address hit", irq_flag, 1'b1);
        step(E_START, C_NONE);
        step(10'd0, C_NONE);
        chk("R7", "addr_seen cleared by start", addr_seen[0], 1'b0);
        sw_write(1'b0);

        // R7: hit after the first byte transfer is outside the first frame.
        step(E_START, C_NONE);
        step(E_RXLD, C_FMT);
        step(E_A1, C_FMT);
        step(10'd0, C_NONE);
        chk("R7", "late hit no flag", irq_flag, 1'b0);
        chk("R7", "late hit no seen", addr_seen[1], 1'b0);

        // R8: general call seen bit
        step(E_START, C_NONE);
        step(E_GC, C_FMT);
        step(10'd0, C_NONE);
        chk("R8", "gcall_seen set", gcall_seen, 1'b1);
        step(E_START, C_NONE);
        step(10'd0, C_NONE);
        chk("R8", "gcall_seen cleared by start", gcall_seen, 1'b0);
        sw_write(1'b0);

        // R10: sticky, write 1 ignored, set beats clear.
        step(E_ARB, C_MST | C_FMT | C_ARBIE);
        repeat (3) step(10'd0, C_NONE);
        chk("R10", "flag held while idle", irq_flag, 1'b1);
        sw_write(1'b1);
        step(10'd0, C_NONE);
        chk("R10", "write 1 ignored", irq_flag, 1'b1);
        sw_write(1'b0);
        drive(E_ARB, C_MST | C_FMT | C_ARBIE);
        step(10'd0, C_NONE);
        chk("R10", "set wins over clear", irq_flag, 1'b1);
        sw_write(1'b0);
        step(10'd0, C_NONE);
        chk("R10", "clear by write 0", irq_flag, 1'b0);

        // R11: enable gating and one-cycle register delay.
        irq_en = 1'b0;
        step(E_ARB, C_MST | C_FMT | C_ARBIE);
        step(10'd0, C_NONE);
        step(10'd0, C_NONE);
        chk("R11", "irq masked by enable", irq_out, 1'b0);
        irq_en = 1'b1;
        #1;
        chk("R11", "irq not yet after enable", irq_out, 1'b0);
        sw_write(1'b0);
        chk("R11", "irq one cycle after enable", irq_out, 1'b1);
        step(10'd0, C_NONE);
        chk("R11", "flag cleared, irq still registered", irq_out, 1'b1);
        chk("R10", "flag cleared", irq_flag, 1'b0);
        step(10'd0, C_NONE);
        chk("R11", "irq falls after flag", irq_out, 1'b0);

        // R12: reset in the middle of a run.
        step(E_START, C_NONE);
        step(E_A0 | E_GC, C_FMT);
        step(10'd0, C_NONE);
        chk("R12", "pre-reset flag", irq_flag, 1'b1);
        rst_n = 1'b0;
        step(10'd0, C_NONE);
        step(10'd0, C_NONE);
        chk("R12", "flag after reset", irq_flag, 1'b0);
        chk("R12", "irq after reset", irq_out, 1'b0);
        chk("R12", "addr_seen after reset", addr_seen[0], 1'b0);
        chk("R12", "gcall_seen after reset", gcall_seen, 1'b0);
        rst_n = 1'b1;
        // R12: first-frame marker cleared, so a hit without start does nothing.
        step(E_A0, C_FMT);
        step(10'd0, C_NONE);
        chk("R12", "no first frame after reset", irq_flag, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule